// File: doc/BRIEF.md
# Peripheral Interrupt Mask and Status Controller

This block gathers thirty-two peripheral interrupt sources into one interrupt line for the processor. Software reaches it through a small register bus. The bus gives access to an enable register and a status register. A source counts as pending only when its status bit and its enable bit are both set. The block registers the OR of all pending sources onto the processor interrupt line. In the same cycle it presents the index of the lowest-numbered pending source, together with a valid flag. When an interrupt arrives while nothing is pending, the valid flag is low, so software can treat the event as spurious.

Most status bits follow the live level of their source, and bus writes to them are dropped. Two positions are different: bit 10 (serial transmit done) and bit 11 (serial receive done). Each of these captures the rising edge of its source input and stays set until software writes a one to that bit. Software changes enables with a read-modify-write of the whole enable register, so that register reads back exactly what was written.

Top module: `perint_ctrl`

## Requirements
- R1: After reset the enable register reads 0x00000000, status bits 10 and 11 read 0, and irq_out, pend_valid and pend_idx are all 0.
- R2: A write to offset 0x0 stores the full 32-bit word in the enable register, and a later read of offset 0x0 returns that word unchanged.
- R3: A read of offset 0x4 returns, for every bit except 10 and 11, the level of the matching irq_src bit in the cycle the read is issued.
- R4: A rising edge on irq_src[10] sets status bit 10 at the next clock, and a rising edge on irq_src[11] sets status bit 11. A source held high does not set the bit again once it has been cleared.
- R5: Writing offset 0x4 with a 1 in bit 10 or bit 11 clears that status bit. A 0 in that position leaves the bit unchanged.
- R6: Writes to offset 0x4 have no effect on status bits other than 10 and 11, and they do not change the enable register.
- R7: When a set edge and a write-one-to-clear hit the same sticky bit in the same cycle, the bit ends up set.
- R8: irq_out is registered. One clock after the pending vector (status AND enable) changes, irq_out equals the OR of that vector.
- R9: When any source is pending, pend_valid is 1 and pend_idx gives the lowest-numbered pending source (0 to 31). It is registered in the same cycle as irq_out.
- R10: When no source is pending, pend_valid is 0 and pend_idx is 0, even if status bits are set under a zero enable.
- R11: Reads of any offset other than 0x0 and 0x4 return zero.
- R12: Read data appears on bus_rdata one clock after the read is issued. A read issued in the cycle right after a write returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_src | input | 32 | Source inputs. Bits 10 and 11 are edge-captured, all other bits are levels |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset: 0x0 enable, 0x4 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read strobe, zero otherwise |
| irq_out | output | 1 | Registered interrupt request to the processor |
| pend_idx | output | 5 | Registered index of the lowest pending source |
| pend_valid | output | 1 | Registered flag: at least one source pending |

## Verification
The encoder and interrupt line are driven with a table of enable/source pairs. The table includes fully masked sources, an all-enabled empty vector, a single source at the top index and a single source at index 0, dense groups whose lowest member sits inside the group, and a source that is only masked away. Together these separate a correct lowest-index pick from a highest-index pick, from an off-by-one, and from logic that ignores the enable. Directed cases then drive the two edge-captured bits. They hold a source high across a clear to show edge and level behaviour are different, write zeros to show the clear acts per bit, and clash a set with a clear to show the set wins. Writes of all-ones to the status offset show the level bits and the enable cannot be touched from there.

// File: rtl/perint_pkg.sv
package perint_pkg;
   // Which register a bus offset selects
   typedef enum logic [1:0] {
      SEL_ENABLE = 2'd0,
      SEL_STATUS = 2'd1,
      SEL_NONE   = 2'd2
   } reg_sel_e;
endpackage

// File: rtl/perint_edge.sv
module perint_edge #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] rise
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= d;
   end

   assign rise = d & ~prev_q;
endmodule

// File: rtl/perint_sticky.sv
module perint_sticky #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q
);
   logic [N-1:0] rise;

   perint_edge #(.W(N)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (lvl),
      .rise (rise)
   );

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       q[i] <= 1'b0;
         else if (rise[i]) q[i] <= 1'b1;   // set beats clear
         else if (clr[i])  q[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/perint_lowenc.sv
module perint_lowenc #(
   parameter int W     = 32,
   parameter int IDX_W = $clog2(W)
) (
   input  logic [W-1:0]     vec,
   output logic [IDX_W-1:0] idx,
   output logic             valid
);
   always_comb begin
      idx   = '0;
      valid = |vec;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/perint_ctrl.sv
module perint_ctrl
   import perint_pkg::*;
#(
   parameter int SRC_N    = 32,
   parameter int ADDR_W   = 4,
   parameter int TXC_BIT  = 10,
   parameter int RXC_BIT  = 11,
   parameter int MASK_OFS = 0,
   parameter int STAT_OFS = 4,
   localparam int IDX_W   = $clog2(SRC_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SRC_N-1:0]  irq_src,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [SRC_N-1:0]  bus_wdata,
   output logic [SRC_N-1:0]  bus_rdata,
   output logic              irq_out,
   output logic [IDX_W-1:0]  pend_idx,
   output logic              pend_valid
);
   // Elaboration-time parameter checks
   if (TXC_BIT >= SRC_N || RXC_BIT >= SRC_N) begin : g_bad_bit
      $error("sticky bit position outside source range");
   end
   if (TXC_BIT == RXC_BIT) begin : g_same_bit
      $error("sticky bit positions must differ");
   end
   if (MASK_OFS == STAT_OFS) begin : g_same_ofs
      $error("register offsets must differ");
   end
   if (SRC_N < 2) begin : g_small
      $error("at least two sources required");
   end

   logic [SRC_N-1:0] mask_q;
   logic [SRC_N-1:0] status;
   logic [SRC_N-1:0] pend;
   logic [1:0]       stk_q;
   logic [1:0]       stk_clr;
   reg_sel_e         rsel;
   logic             wr_mask, wr_stat, rd_any;
   logic [IDX_W-1:0] idx_c;
   logic             vld_c;

   // Offset decode
   always_comb begin
      if (bus_addr == ADDR_W'(MASK_OFS))      rsel = SEL_ENABLE;
      else if (bus_addr == ADDR_W'(STAT_OFS)) rsel = SEL_STATUS;
      else                                    rsel = SEL_NONE;
   end

   assign wr_mask = bus_sel &  bus_wr & (rsel == SEL_ENABLE);
   assign wr_stat = bus_sel &  bus_wr & (rsel == SEL_STATUS);
   assign rd_any  = bus_sel & ~bus_wr;

   // Enable register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (wr_mask) mask_q <= bus_wdata;
   end

   // Sticky bits: index 0 = transmit done, index 1 = receive done
   assign stk_clr = wr_stat ? {bus_wdata[RXC_BIT], bus_wdata[TXC_BIT]} : 2'b00;

   perint_sticky #(.N(2)) u_sticky (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  ({irq_src[RXC_BIT], irq_src[TXC_BIT]}),
      .clr  (stk_clr),
      .q    (stk_q)
   );

   // Status assembly: sticky positions from capture flops, rest live
   for (genvar i = 0; i < SRC_N; i++) begin : g_stat
      if (i == TXC_BIT) begin : g_tx
         assign status[i] = stk_q[0];
      end else if (i == RXC_BIT) begin : g_rx
         assign status[i] = stk_q[1];
      end else begin : g_lvl
         assign status[i] = irq_src[i];
      end
   end

   assign pend = status & mask_q;

   perint_lowenc #(.W(SRC_N), .IDX_W(IDX_W)) u_enc (
      .vec  (pend),
      .idx  (idx_c),
      .valid(vld_c)
   );

   // Registered outputs toward the processor
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_out    <= 1'b0;
         pend_idx   <= '0;
         pend_valid <= 1'b0;
      end else begin
         irq_out    <= |pend;
         pend_idx   <= idx_c;
         pend_valid <= vld_c;
      end
   end

   // Read data, one cycle latency, zero when idle or unmapped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (rd_any) begin
         unique case (rsel)
            SEL_ENABLE: bus_rdata <= mask_q;
            SEL_STATUS: bus_rdata <= status;
            default:    bus_rdata <= '0;
         endcase
      end else begin
         bus_rdata <= '0;
      end
   end
endmodule

// File: rtl/perint_ctrl_chk.sv
module perint_ctrl_chk #(
   parameter int SRC_N    = 32,
   parameter int ADDR_W   = 4,
   parameter int TXC_BIT  = 10,
   parameter int RXC_BIT  = 11,
   parameter int MASK_OFS = 0,
   parameter int STAT_OFS = 4,
   localparam int IDX_W   = $clog2(SRC_N)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [SRC_N-1:0]  irq_src,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [SRC_N-1:0]  bus_wdata,
   input logic [SRC_N-1:0]  bus_rdata,
   input logic              irq_out,
   input logic [IDX_W-1:0]  pend_idx,
   input logic              pend_valid,
   input logic [SRC_N-1:0]  mask_q,
   input logic [SRC_N-1:0]  status
);
   localparam logic [SRC_N-1:0] STICKY =
      (SRC_N'(1) << TXC_BIT) | (SRC_N'(1) << RXC_BIT);

   logic [SRC_N-1:0] pend_d;
   logic             tx_prev, rx_prev;
   logic             tx_rise, rx_rise;
   logic [SRC_N-1:0] below;
   logic             stat_wr, stat_rd, mask_wr, mask_rd, other_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_d  <= '0;
         tx_prev <= 1'b0;
         rx_prev <= 1'b0;
      end else begin
         pend_d  <= status & mask_q;
         tx_prev <= irq_src[TXC_BIT];
         rx_prev <= irq_src[RXC_BIT];
      end
   end

   assign tx_rise  = irq_src[TXC_BIT] & ~tx_prev;
   assign rx_rise  = irq_src[RXC_BIT] & ~rx_prev;
   assign below    = (SRC_N'(1) << pend_idx) - SRC_N'(1);
   assign stat_wr  = bus_sel & bus_wr & (bus_addr == ADDR_W'(STAT_OFS));
   assign stat_rd  = bus_sel & ~bus_wr & (bus_addr == ADDR_W'(STAT_OFS));
   assign mask_wr  = bus_sel & bus_wr & (bus_addr == ADDR_W'(MASK_OFS));
   assign mask_rd  = bus_sel & ~bus_wr & (bus_addr == ADDR_W'(MASK_OFS));
   assign other_rd = bus_sel & ~bus_wr & ~stat_rd & ~mask_rd;

   p_mask_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr |=> mask_q == $past(bus_wdata));

   p_level_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |=> (bus_rdata & ~STICKY) == ($past(irq_src) & ~STICKY));

   p_tx_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_rise |=> status[TXC_BIT]);

   p_rx_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_rise |=> status[RXC_BIT]);

   p_tx_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && bus_wdata[TXC_BIT] && !tx_rise) |=> !status[TXC_BIT]);

   p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_rise && !(stat_wr && bus_wdata[TXC_BIT])) |=> $stable(status[TXC_BIT]));

   p_irq_agree_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out == pend_valid);

   p_lowest_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pend_valid |-> (pend_d[pend_idx] && ((pend_d & below) == '0)));

   p_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_valid |-> (pend_d == '0 && pend_idx == '0));

   p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
      other_rd |=> bus_rdata == '0);

   p_read_lat_r12: assert property (@(posedge clk) disable iff (!rst_n)
      mask_rd |=> bus_rdata == $past(mask_q));
endmodule

bind perint_ctrl perint_ctrl_chk #(
   .SRC_N   (SRC_N),
   .ADDR_W  (ADDR_W),
   .TXC_BIT (TXC_BIT),
   .RXC_BIT (RXC_BIT),
   .MASK_OFS(MASK_OFS),
   .STAT_OFS(STAT_OFS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_src   (irq_src),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .irq_out   (irq_out),
   .pend_idx  (pend_idx),
   .pend_valid(pend_valid),
   .mask_q    (mask_q),
   .status    (status)
);

// File: tb/perint_ctrl_test.sv
module perint_ctrl_test;
   localparam logic [3:0] A_MASK = 4'h0;
   localparam logic [3:0] A_STAT = 4'h4;
   localparam int NV = 8;

   // enable, source level, expected valid, expected index
   localparam logic [31:0] T_MASK [NV] = '{
      32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0F00,
      32'hF000_00F0, 32'hFFFF_FFFE, 32'h0000_0001, 32'h5555_0000};
   localparam logic [31:0] T_SRC  [NV] = '{
      32'hFFFF_F3FF, 32'h0000_0000, 32'h8000_0000, 32'h0000_0300,
      32'h0000_F0F0, 32'h0000_0001, 32'h0000_0001, 32'hFFFF_F3FF};
   localparam logic        T_VLD  [NV] = '{1'b0, 1'b0, 1'b1, 1'b1,
                                           1'b1, 1'b0, 1'b1, 1'b1};
   localparam logic [4:0]  T_IDX  [NV] = '{5'd0, 5'd0, 5'd31, 5'd8,
                                           5'd4, 5'd0, 5'd0, 5'd16};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_src = '0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_out;
   logic [4:0]  pend_idx;
   logic        pend_valid;

   int checks = 0;
   int fails  = 0;
   logic [31:0] rd;

   always #5 clk = ~clk;

   perint_ctrl uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_src   (irq_src),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_out   (irq_out),
      .pend_idx  (pend_idx),
      .pend_valid(pend_valid)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(posedge clk); @(negedge clk);
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic check_out(input string req, input logic v, input logic [4:0] i);
      check({req, " irq_out"},    32'(irq_out),    32'(v));
      check({req, " pend_valid"}, 32'(pend_valid), 32'(v));
      check({req, " pend_idx"},   32'(pend_idx),   32'(i));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check_out("R1", 1'b0, 5'd0);
      bus_read(A_MASK, rd);
      check("R1 enable", rd, 32'h0);
      bus_read(A_STAT, rd);
      check("R1 status", rd, 32'h0);

      // Table of enable/source pairs: R2 R3 R8 R9 R10 R12
      for (int k = 0; k < NV; k++) begin
         irq_src = T_SRC[k];
         bus_write(A_MASK, T_MASK[k]);
         bus_read(A_MASK, rd);            // issued the cycle after the write
         check("R2 R12 enable readback", rd, T_MASK[k]);
         bus_read(A_STAT, rd);
         check("R3 status levels", rd, T_SRC[k]);
         check_out("R8 R9 R10", T_VLD[k], T_IDX[k]);
      end

      // R4, R5: edge capture on bit 10, cleared while source stays high
      irq_src = '0;
      bus_write(A_MASK, 32'h0000_0C00);
      irq_src[10] = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_read(A_STAT, rd);
      check("R4 tx set", rd, 32'h0000_0400);
      check_out("R4 R9", 1'b1, 5'd10);
      bus_write(A_STAT, 32'h0000_0400);
      bus_read(A_STAT, rd);
      check("R4 R5 cleared with source held high", rd, 32'h0);
      check_out("R10 none pending", 1'b0, 5'd0);

      // R4, R5: receive pulse, zero write keeps it, one write clears it
      irq_src[10] = 1'b0;
      irq_src[11] = 1'b1;
      @(posedge clk); @(negedge clk);
      irq_src[11] = 1'b0;
      bus_write(A_STAT, 32'h0000_0000);
      bus_read(A_STAT, rd);
      check("R5 zero write keeps rx", rd, 32'h0000_0800);
      bus_write(A_MASK, 32'hFFFF_FFFF);
      irq_src = 32'h0010_0000;
      bus_read(A_STAT, rd);
      check("R4 rx with level", rd, 32'h0010_0800);
      check_out("R9 sticky lowest", 1'b1, 5'd11);
      bus_write(A_STAT, 32'h0000_0800);
      bus_read(A_STAT, rd);
      check("R5 rx cleared", rd, 32'h0010_0000);
      check_out("R9 level next", 1'b1, 5'd20);

      // R7: set and clear in the same cycle
      irq_src[10] = 1'b1;
      bus_write(A_STAT, 32'h0000_0400);
      bus_read(A_STAT, rd);
      check("R7 set wins", rd, 32'h0010_0400);
      check_out("R7", 1'b1, 5'd10);
      irq_src[10] = 1'b0;
      bus_write(A_STAT, 32'h0000_0400);

      // R6: status writes leave level bits and enable alone
      bus_write(A_MASK, 32'h0000_0000);
      irq_src = 32'h0012_0001;
      bus_write(A_STAT, 32'hFFFF_F3FF);
      bus_read(A_STAT, rd);
      check("R6 status unaffected", rd, 32'h0012_0001);
      bus_read(A_MASK, rd);
      check("R6 enable unaffected", rd, 32'h0000_0000);
      check_out("R10 masked status", 1'b0, 5'd0);

      // R11: unmapped offsets read zero
      bus_write(A_MASK, 32'hDEAD_BEEF);
      bus_read(4'h8, rd);
      check("R11 offset 8", rd, 32'h0);
      bus_read(4'hC, rd);
      check("R11 offset C", rd, 32'h0);
      bus_read(4'h2, rd);
      check("R11 offset 2", rd, 32'h0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule